// File: doc/BRIEF.md
# Branch Target Buffer with Return-Address Stack

This block sits in the fetch stage next to the direction predictor. For each fetch address it reports, in the same cycle, whether the address belongs to a branch that is known to be taken, and it gives the address fetch should go to next. Known branches are held in a direct-mapped table of 64 entries. Each entry keeps its own tag, so a stored target is only used when the fetch address really is the branch that was recorded, and not some other branch that happens to share the slot.

Return instructions are handled differently. Their entry in the table only marks them as returns. Their target is taken from the top of an 8-deep return-address stack. The resolve port writes and refreshes entries when branches complete. The same port pushes the address of the following instruction for calls and pops the stack for returns. Any change made through the resolve port becomes visible at the lookup on the following clock.

Top module: `btb_ras_top`

## Requirements
- R1: After reset every table entry is invalid and the stack is empty. Every lookup misses (pred_hit=0, pred_taken=0) and pred_target equals fetch_pc+4.
- R2: A resolve with upd_valid=1 and upd_taken=1 writes an entry for upd_pc. Slot index is bits 7:2 of the address and the tag is bits 31:8. A later lookup of that address hits with pred_taken=1. For upd_kind 2'b00 (plain branch) and 2'b01 (call), pred_target is upd_target.
- R3: A lookup whose index matches a valid entry but whose tag differs misses, and pred_target equals fetch_pc+4.
- R4: A not-taken resolve (upd_valid=1, upd_taken=0) invalidates the slot only when the slot's stored tag matches upd_pc. With a different tag, the stored entry keeps hitting.
- R5: A taken resolve of an address already present overwrites its target, and the new target is predicted.
- R6: A resolve with upd_kind=2'b01 (call) pushes upd_pc+4 on the stack. A lookup that hits an entry of kind 2'b10 (return) predicts the current top of the stack.
- R7: A resolve with upd_kind=2'b10 (return) pops the stack, so return targets come out in last-in first-out order.
- R8: The stack holds 8 addresses. A push onto a full stack discards the oldest address and keeps the 8 newest.
- R9: A lookup that hits a return entry while the stack is empty is reported as a miss with pred_target = fetch_pc+4. A return resolve on an empty stack leaves it empty.
- R10: The lookup is combinational. A resolve takes effect at the next rising clock edge, so a lookup of the same address in the resolve cycle still sees the old state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Address being fetched |
| pred_hit | output | 1 | Lookup found a usable entry |
| pred_taken | output | 1 | Predicted taken |
| pred_target | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A branch resolves this cycle |
| upd_pc | input | 32 | Address of the resolving branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved target address |
| upd_kind | input | 2 | 00 plain branch, 01 call, 10 return |

## Verification
The assertions assume that upd_kind never takes the unused value 2'b11. They also assume the resolve port carries at most one branch per cycle, so a push and a pop never coincide. The stimulus draws kinds only from the three legal codes and presents a single resolve at a time. Directed sequences build up stack depth past its capacity and create index collisions between addresses that differ only in the tag bits. A random phase uses a small pool of addresses, so that hits, aliasing, invalidations and stack underflow all occur often.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    BR_PLAIN = 2'b00,
    BR_CALL  = 2'b01,
    BR_RET   = 2'b10
  } br_kind_e;
endpackage

// File: rtl/btb_table.sv
module btb_table #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_target,
  output logic [1:0]        lk_kind,
  input  logic              wr_en,
  input  logic              inv_en,
  input  logic [ADDR_W-1:0] wr_pc,
  input  logic [ADDR_W-1:0] wr_target,
  input  logic [1:0]        wr_kind
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W - 2;

  logic [TAG_W-1:0]  tag_mem  [ENTRIES];
  logic [ADDR_W-1:0] tgt_mem  [ENTRIES];
  logic [1:0]        kind_mem [ENTRIES];
  logic [ENTRIES-1:0] vld;

  logic [IDX_W-1:0] lk_idx, wr_idx;
  logic [TAG_W-1:0] lk_tag, wr_tag;

  assign lk_idx = lk_pc[IDX_W+1:2];
  assign lk_tag = lk_pc[ADDR_W-1:IDX_W+2];
  assign wr_idx = wr_pc[IDX_W+1:2];
  assign wr_tag = wr_pc[ADDR_W-1:IDX_W+2];

  // Payload storage: no reset, one write port, asynchronous reads.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      tgt_mem[wr_idx]  <= wr_target;
      kind_mem[wr_idx] <= wr_kind;
    end
  end

  // Valid bits live in flops so reset clears the whole table at once.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else if (wr_en) begin
      vld[wr_idx] <= 1'b1;
    end else if (inv_en && vld[wr_idx] && (tag_mem[wr_idx] == wr_tag)) begin
      vld[wr_idx] <= 1'b0;
    end
  end

  assign lk_hit    = vld[lk_idx] && (tag_mem[lk_idx] == lk_tag);
  assign lk_target = tgt_mem[lk_idx];
  assign lk_kind   = kind_mem[lk_idx];
endmodule

// File: rtl/btb_ras.sv
module btb_ras #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [ADDR_W-1:0]            push_val,
  input  logic                         pop,
  output logic [ADDR_W-1:0]            top,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, ptr_inc, ptr_dec;

  assign ptr_inc = (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + PTR_W'(1);
  assign ptr_dec = (wr_ptr == '0) ? PTR_W'(DEPTH-1) : wr_ptr - PTR_W'(1);

  // Circular buffer: a push on a full stack overwrites the oldest slot.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      count  <= '0;
    end else if (push) begin
      wr_ptr <= ptr_inc;
      if (count != CNT_W'(DEPTH)) count <= count + CNT_W'(1);
    end else if (pop && (count != '0)) begin
      wr_ptr <= ptr_dec;
      count  <= count - CNT_W'(1);
    end
  end

  assign top = mem[ptr_dec];
endmodule

// File: rtl/btb_ras_top.sv
module btb_ras_top #(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 6,
  parameter int RAS_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_target,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic [1:0]        upd_kind
);
  import btb_pkg::*;
  localparam int CNT_W = $clog2(RAS_DEPTH+1);

  logic              tbl_hit;
  logic [ADDR_W-1:0] tbl_target;
  logic [1:0]        tbl_kind;
  logic [ADDR_W-1:0] ras_top;
  logic [CNT_W-1:0]  ras_cnt;
  logic [ADDR_W-1:0] seq_pc;
  logic              do_push, do_pop;

  assign do_push = upd_valid && (upd_kind == BR_CALL);
  assign do_pop  = upd_valid && (upd_kind == BR_RET);

  btb_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
    .clk       (clk),
    .rst       (rst),
    .lk_pc     (fetch_pc),
    .lk_hit    (tbl_hit),
    .lk_target (tbl_target),
    .lk_kind   (tbl_kind),
    .wr_en     (upd_valid && upd_taken),
    .inv_en    (upd_valid && !upd_taken),
    .wr_pc     (upd_pc),
    .wr_target (upd_target),
    .wr_kind   (upd_kind)
  );

  btb_ras #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk      (clk),
    .rst      (rst),
    .push     (do_push),
    .push_val (upd_pc + ADDR_W'(4)),
    .pop      (do_pop),
    .top      (ras_top),
    .count    (ras_cnt)
  );

  assign seq_pc = fetch_pc + ADDR_W'(4);

  always_comb begin
    pred_hit    = 1'b0;
    pred_target = seq_pc;
    if (tbl_hit) begin
      if (tbl_kind == BR_RET) begin
        if (ras_cnt != '0) begin
          pred_hit    = 1'b1;
          pred_target = ras_top;
        end
      end else begin
        pred_hit    = 1'b1;
        pred_target = tbl_target;
      end
    end
  end

  assign pred_taken = pred_hit;
endmodule

// File: rtl/btb_ras_checker.sv
module btb_ras_checker #(
  parameter int ADDR_W    = 32,
  parameter int RAS_DEPTH = 8,
  parameter int CNT_W     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              pred_hit,
  input logic              pred_taken,
  input logic [ADDR_W-1:0] pred_target,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_pc,
  input logic              upd_taken,
  input logic [ADDR_W-1:0] upd_target,
  input logic [1:0]        upd_kind,
  input logic [ADDR_W-1:0] ras_top,
  input logic [CNT_W-1:0]  ras_cnt
);
  // R2: an installed non-return branch is found on the next cycle.
  a_r2_install_visible: assert property (@(posedge clk) disable iff (rst)
    upd_valid && upd_taken && (upd_kind != 2'b10) |=>
      (fetch_pc != $past(upd_pc)) || (pred_hit && pred_taken && pred_target == $past(upd_target)));

  // R4: a not-taken resolve leaves nothing that hits for that address.
  a_r4_not_taken_clears: assert property (@(posedge clk) disable iff (rst)
    upd_valid && !upd_taken |=>
      (fetch_pc[ADDR_W-1:2] != $past(upd_pc[ADDR_W-1:2])) || !pred_hit);

  // R3: a miss always falls through to the sequential address.
  a_r3_miss_sequential: assert property (@(posedge clk) disable iff (rst)
    !pred_hit |-> (pred_target == fetch_pc + ADDR_W'(4)) && !pred_taken);

  // R6: a call leaves its return address on top of the stack.
  a_r6_call_pushes: assert property (@(posedge clk) disable iff (rst)
    upd_valid && (upd_kind == 2'b01) |=>
      (ras_top == $past(upd_pc) + ADDR_W'(4)) && (ras_cnt != '0));

  // R7: a return on a non-empty stack removes exactly one address.
  a_r7_return_pops: assert property (@(posedge clk) disable iff (rst)
    upd_valid && (upd_kind == 2'b10) && (ras_cnt != '0) |=>
      ras_cnt == $past(ras_cnt) - CNT_W'(1));

  // R8: the stack depth never exceeds its capacity.
  a_r8_depth_bound: assert property (@(posedge clk) disable iff (rst)
    ras_cnt <= CNT_W'(RAS_DEPTH));
endmodule

bind btb_ras_top btb_ras_checker #(
  .ADDR_W(ADDR_W), .RAS_DEPTH(RAS_DEPTH), .CNT_W($clog2(RAS_DEPTH+1))
) u_chk (
  .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
  .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
  .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
  .upd_target(upd_target), .upd_kind(upd_kind),
  .ras_top(ras_top), .ras_cnt(ras_cnt)
);

// File: tb/tb_btb_ras_top.sv
module tb_btb_ras_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_pc = '0;
  logic        pred_hit, pred_taken;
  logic [31:0] pred_target;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;
  logic [1:0]  upd_kind = 2'b00;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Behavioural reference: full addresses per slot, stack as a queue.
  bit          m_v    [64];
  logic [31:0] m_pc   [64];
  logic [31:0] m_tgt  [64];
  logic [1:0]  m_kind [64];
  logic [31:0] m_ras  [$];

  always #5 clk = ~clk;

  btb_ras_top dut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_kind(upd_kind)
  );

  task automatic model_lookup(input logic [31:0] pc, output bit hit, output logic [31:0] tgt);
    int i = int'(pc[7:2]);
    hit = 0;
    tgt = pc + 32'd4;
    if (m_v[i] && m_pc[i][31:2] == pc[31:2]) begin
      if (m_kind[i] == 2'b10) begin
        if (m_ras.size() > 0) begin hit = 1; tgt = m_ras[m_ras.size()-1]; end
      end else begin
        hit = 1; tgt = m_tgt[i];
      end
    end
  endtask

  task automatic model_update();
    int i = int'(upd_pc[7:2]);
    if (!upd_valid) return;
    if (upd_taken) begin
      m_v[i] = 1; m_pc[i] = upd_pc; m_tgt[i] = upd_target; m_kind[i] = upd_kind;
    end else if (m_v[i] && m_pc[i][31:2] == upd_pc[31:2]) begin
      m_v[i] = 0;
    end
    if (upd_kind == 2'b01) begin
      m_ras.push_back(upd_pc + 32'd4);
      if (m_ras.size() > 8) void'(m_ras.pop_front());
    end else if (upd_kind == 2'b10 && m_ras.size() > 0) begin
      void'(m_ras.pop_back());
    end
  endtask

  // One cycle: drive, compare the combinational lookup, then clock the model.
  task automatic step(input string req, input logic [31:0] fpc, input bit uv,
                      input logic [31:0] upc, input bit utk,
                      input logic [31:0] utg, input logic [1:0] uk);
    bit eh; logic [31:0] et;
    fetch_pc = fpc; upd_valid = uv; upd_pc = upc;
    upd_taken = utk; upd_target = utg; upd_kind = uk;
    #1;
    model_lookup(fpc, eh, et);
    checks++;
    if (pred_hit !== eh || pred_taken !== eh || pred_target !== et) begin
      errors++;
      $display("FAIL %s pc=%h actual hit=%b taken=%b tgt=%h expected hit=%b taken=%b tgt=%h",
               req, fpc, pred_hit, pred_taken, pred_target, eh, eh, et);
    end
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic look(input string req, input logic [31:0] fpc);
    step(req, fpc, 0, 32'h0, 0, 32'h0, 2'b00);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) m_v[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: empty after reset
    look("R1", 32'h0000_1000);
    look("R1", 32'h0000_1004);
    // R10: same-cycle lookup sees the old state; R2: next cycle hits
    step("R10", 32'h0000_1004, 1, 32'h0000_1004, 1, 32'h0000_2000, 2'b00);
    look("R2", 32'h0000_1004);
    // R5: refresh target
    step("R5", 32'h0000_0000, 1, 32'h0000_1004, 1, 32'h0000_3000, 2'b00);
    look("R5", 32'h0000_1004);
    // R3: same index, different tag
    look("R3", 32'h0000_1104);
    // R4: not-taken with other tag keeps entry; with own tag removes it
    step("R4", 32'h0, 1, 32'h0000_1104, 0, 32'h0, 2'b00);
    look("R4", 32'h0000_1004);
    step("R4", 32'h0, 1, 32'h0000_1004, 0, 32'h0, 2'b00);
    look("R4", 32'h0000_1004);
    // R9: return entry with empty stack
    step("R9", 32'h0, 1, 32'h0000_5010, 1, 32'h0, 2'b10);
    look("R9", 32'h0000_5010);
    // R6: call pushes pc+4; return predicts top
    step("R6", 32'h0, 1, 32'h0000_4000, 1, 32'h0000_5000, 2'b01);
    look("R6", 32'h0000_5010);
    look("R6", 32'h0000_4000);
    // R7: nested calls then pops in LIFO order
    step("R7", 32'h0, 1, 32'h0000_4100, 1, 32'h0000_5000, 2'b01);
    step("R7", 32'h0, 1, 32'h0000_4200, 1, 32'h0000_5000, 2'b01);
    look("R7", 32'h0000_5010);
    for (int k = 0; k < 4; k++) begin
      step("R7", 32'h0000_5010, 1, 32'h0000_5010, 1, 32'h0, 2'b10);
      look("R7", 32'h0000_5010);
    end
    // R8: overflow with ten calls, then drain past empty
    for (int k = 0; k < 10; k++)
      step("R8", 32'h0000_5010, 1, 32'h0000_6000 + 32'(k * 256), 1, 32'h0000_7000, 2'b01);
    for (int k = 0; k < 10; k++) begin
      look("R8", 32'h0000_5010);
      step("R8", 32'h0000_5010, 1, 32'h0000_5010, 1, 32'h0, 2'b10);
    end
    look("R9", 32'h0000_5010);

    // Random mix over a small address pool: R2 R3 R4 R6 R7 R8
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] a, f;
      a = {22'h0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), 4'h0};
      f = {22'h0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), 4'h0};
      step("R2", f, 1'($urandom_range(0, 1)), a, 1'($urandom_range(0, 3) != 0),
           32'($urandom), 2'($urandom_range(0, 2)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule